// File: doc/BRIEF.md
# Index-Synchronized Quadrature Position Counter

This block turns the three raw signals of an incremental shaft encoder, the two quadrature channels A and B and the once-per-turn index Z, into a position count that stays inside one mechanical revolution. Each raw input first passes through a two-flop synchronizer and a short stability filter. The cleaned A and B levels are then decoded at four times the line count: every rising and every falling edge of either channel moves the count by one. The order of the edges gives the direction of rotation.

The count wraps in both directions, so it always lies between zero and four times the line count minus one. A rising edge of the cleaned index signal forces the count to zero. This recovers from any missed edges and ties zero to the mechanical index position. A sticky flag reports that the first index has been seen, which tells downstream control logic that the count is now absolute rather than relative to power-up. A one-cycle strobe marks each counted edge, and a separate one-cycle strobe marks an illegal transition in which both channels change in the same cycle.

Top module: `quad_index_counter`

## Requirements
- R1: A level change on A, B or Z takes effect only once the synchronized level has held for FILT_LEN (default 3) consecutive clocks. Shorter pulses are dropped and change no output.
- R2: Each single change of the cleaned {A,B} pair moves `position` by one. The sequence 00→10→11→01→00, with A leading, counts up. The reverse sequence counts down.
- R3: `position` always lies in 0 .. LINES*4−1 (default 0 .. 9999).
- R4: A count up from LINES*4−1 gives 0, and a count down from 0 gives LINES*4−1.
- R5: `stepPulse` is high for exactly one clock per counted edge. `dirUp` holds the direction of the last counted edge, with 1 meaning up.
- R6: When A and B both change in the same cycle, `position` does not change, no step is signalled, and `errPulse` is high for one clock.
- R7: A rising edge of the cleaned Z sets `position` to 0. If a step arrives in the same cycle, the index takes priority.
- R8: `indexSeen` is cleared by reset, set by the first Z rising edge, and then stays set.
- R9: While Z stays high, the count is not zeroed again, and edges keep counting normally.
- R10: After reset, `position` is 0, `indexSeen` is 0, `dirUp` is 1, and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Raw quadrature channel A |
| encB | input | 1 | Raw quadrature channel B |
| encZ | input | 1 | Raw index pulse |
| position | output | CNT_W (14) | Count within one revolution |
| dirUp | output | 1 | Direction of the last counted edge (1 = up) |
| indexSeen | output | 1 | Set once the first index edge has been seen |
| stepPulse | output | 1 | One-cycle strobe per counted edge |
| errPulse | output | 1 | One-cycle strobe on an illegal double transition |

## Verification
Some properties are checked by assertions on every cycle. The count never leaves its range. The count wraps correctly at the top of the range. An index edge leaves the count at zero and the flag set, and the flag never drops. A counted step always matches exactly one changed filtered channel. A filtered level only ever takes on the value the synchronizer presented. Other behaviour needs the bench scenarios to show it: the direction of long random walks across the wrap points, the filter dropping short glitches, the count ignoring simultaneous A/B changes, and the count carrying on while Z stays high. These depend on multi-cycle input sequences rather than on a single-cycle relation.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  // Strobes handed from the decode control to the count datapath
  typedef struct packed {
    logic step;   // one legal quadrature edge this cycle
    logic up;     // direction of that edge
    logic zero;   // index rising edge
    logic err;    // both channels moved together
  } qdStrobe_t;

endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      holdCnt  <= '0;
      cleanOut <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != cleanOut) begin
        if (holdCnt == CW'(FILT_LEN - 1)) begin
          cleanOut <= syncQ[1];
          holdCnt  <= '0;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end else begin
        holdCnt <= '0;
      end
    end
  end

  // R1
  filt_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cleanOut) |-> cleanOut == $past(syncQ[1]));

endmodule

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      aF,
  input  logic      bF,
  input  logic      zF,
  output qdStrobe_t strobe
);
  logic prevA, prevB, prevZ;
  logic aChg, bChg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
      prevZ <= 1'b0;
    end else begin
      prevA <= aF;
      prevB <= bF;
      prevZ <= zF;
    end
  end

  always_comb begin
    aChg        = aF ^ prevA;
    bChg        = bF ^ prevB;
    strobe.err  = aChg & bChg;
    strobe.step = aChg ^ bChg;
    strobe.up   = aChg ? (aF ^ prevB) : ~(bF ^ prevA);
    strobe.zero = zF & ~prevZ;
  end

  // R2
  step_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> $countones({aF, bF} ^ {$past(aF), $past(bF)}) == 1);

endmodule

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int LINES = 2500
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  qdStrobe_t                           strobe,
  output logic [$clog2(LINES*4)-1:0]          position,
  output logic                                dirUp,
  output logic                                indexSeen,
  output logic                                stepPulse,
  output logic                                errPulse
);
  localparam int COUNTS = LINES * 4;
  localparam int CNT_W  = $clog2(COUNTS);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(COUNTS - 1);

  logic [CNT_W-1:0] nextUp, nextDn;

  always_comb begin
    nextUp = (position == MAXC) ? '0 : position + 1'b1;
    nextDn = (position == '0) ? MAXC : position - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      position  <= '0;
      dirUp     <= 1'b1;
      indexSeen <= 1'b0;
      stepPulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      stepPulse <= strobe.step;
      errPulse  <= strobe.err;
      if (strobe.step) dirUp <= strobe.up;
      if (strobe.zero) begin
        position  <= '0;
        indexSeen <= 1'b1;
      end else if (strobe.step) begin
        position <= strobe.up ? nextUp : nextDn;
      end
    end
  end

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    position <= MAXC);

  // R4
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && strobe.up && !strobe.zero && position == MAXC) |=> position == '0);

  // R7
  index_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zero |=> (position == '0) && indexSeen);

  // R8
  index_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    indexSeen |=> indexSeen);

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.err && !strobe.zero) |=> $stable(position) && errPulse && !stepPulse);

endmodule

// File: rtl/quad_index_counter.sv
module quad_index_counter
  import qdec_pkg::*;
#(
  parameter int LINES    = 2500,
  parameter int FILT_LEN = 3,
  localparam int CNT_W   = $clog2(LINES * 4)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  logic             encZ,
  output logic [CNT_W-1:0] position,
  output logic             dirUp,
  output logic             indexSeen,
  output logic             stepPulse,
  output logic             errPulse
);
  localparam int NCH = 3;

  logic [NCH-1:0] rawVec;
  logic [NCH-1:0] cleanVec;
  qdStrobe_t      strobe;

  assign rawVec = {encZ, encB, encA};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cond
    qdec_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawVec[ch]),
      .cleanOut (cleanVec[ch])
    );
  end

  qdec_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .aF     (cleanVec[0]),
    .bF     (cleanVec[1]),
    .zF     (cleanVec[2]),
    .strobe (strobe)
  );

  qdec_datapath #(.LINES(LINES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .position  (position),
    .dirUp     (dirUp),
    .indexSeen (indexSeen),
    .stepPulse (stepPulse),
    .errPulse  (errPulse)
  );

  // R5
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stepPulse && errPulse));

endmodule

// File: tb/quad_index_counter_tb.sv
module quad_index_counter_tb;
  localparam int LINES  = 2500;
  localparam int COUNTS = LINES * 4;
  localparam int HOLD   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic encA = 1'b0, encB = 1'b0, encZ = 1'b0;
  logic [13:0] position;
  logic dirUp, indexSeen, stepPulse, errPulse;

  int total = 0;
  int bad = 0;
  int stepSeen = 0;
  int errSeen = 0;
  int expPos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_index_counter #(.LINES(LINES)) u_dut (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encZ(encZ),
    .position(position), .dirUp(dirUp), .indexSeen(indexSeen),
    .stepPulse(stepPulse), .errPulse(errPulse)
  );

  always @(negedge clk) begin
    if (rstN && stepPulse) stepSeen++;
    if (rstN && errPulse)  errSeen++;
  end

  function automatic int grayIdx(logic a, logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] grayAt(int idx);
    case (idx & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int modelStep(int pos, bit up);
    if (up) return (pos == COUNTS - 1) ? 0 : pos + 1;
    return (pos == 0) ? COUNTS - 1 : pos - 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic moveOne(bit up);
    logic [1:0] nxt;
    nxt = grayAt(grayIdx(encA, encB) + (up ? 1 : 3));
    @(negedge clk);
    {encA, encB} = nxt;
    expPos = modelStep(expPos, up);
    waitCyc(HOLD);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    int s0;
    int dummy;
    dummy = $urandom(32'h1234_5eed);
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    // R10 reset state
    chk("R10 position", int'(position), 0);
    chk("R10 indexSeen", int'(indexSeen), 0);
    chk("R10 dirUp", int'(dirUp), 1);
    chk("R10 strobes", int'({stepPulse, errPulse}), 0);

    // R4 down-wrap from 0, then up-wrap back
    moveOne(1'b0);
    chk("R4 wrap down", int'(position), COUNTS - 1);
    chk("R5 dirUp down", int'(dirUp), 0);
    moveOne(1'b1);
    chk("R4 wrap up", int'(position), 0);
    chk("R5 dirUp up", int'(dirUp), 1);
    chk("R5 step strobes", stepSeen, 2);

    // R2 up and down runs
    for (int i = 0; i < 5; i++) moveOne(1'b1);
    chk("R2 count up", int'(position), 5);
    for (int i = 0; i < 2; i++) moveOne(1'b0);
    chk("R2 count down", int'(position), 3);

    // R1 short glitch on A ignored
    s0 = stepSeen;
    @(negedge clk); encA = ~encA;
    waitCyc(2);
    encA = ~encA;
    waitCyc(HOLD);
    chk("R1 glitch position", int'(position), expPos);
    chk("R1 glitch strobe", stepSeen, s0);

    // R6 both channels together
    s0 = stepSeen;
    @(negedge clk); encA = ~encA; encB = ~encB;
    waitCyc(HOLD);
    chk("R6 illegal position", int'(position), expPos);
    chk("R6 illegal err", errSeen, 1);
    chk("R6 illegal no step", stepSeen, s0);

    // R8 flag before index, R7 index zeroes
    chk("R8 before index", int'(indexSeen), 0);
    @(negedge clk); encZ = 1'b1;
    waitCyc(HOLD);
    expPos = 0;
    chk("R7 index zero", int'(position), 0);
    chk("R8 index seen", int'(indexSeen), 1);

    // R9 Z still high: counting continues
    moveOne(1'b1);
    moveOne(1'b1);
    chk("R9 count while Z high", int'(position), 2);
    @(negedge clk); encZ = 1'b0;
    waitCyc(HOLD);
    chk("R9 Z fall no zero", int'(position), 2);

    // R1 short Z glitch does not re-zero
    @(negedge clk); encZ = 1'b1;
    waitCyc(2);
    encZ = 1'b0;
    waitCyc(HOLD);
    chk("R1 Z glitch", int'(position), 2);

    // R2 R4 R5 random walk around the wrap point
    for (int i = 0; i < 5; i++) moveOne(1'b0);
    chk("R4 below zero", int'(position), COUNTS - 3);
    for (int i = 0; i < 400; i++) begin
      bit up;
      s0 = stepSeen;
      up = (($urandom % 100) < 55);
      moveOne(up);
      chk("R2 random position", int'(position), expPos);
      chk("R5 random step", stepSeen - s0, 1);
      chk("R5 random dir", int'(dirUp), int'(up));
    end

    // R7 second index re-zeroes again, R8 stays set
    @(negedge clk); encZ = 1'b1;
    waitCyc(HOLD);
    encZ = 1'b0;
    waitCyc(HOLD);
    expPos = 0;
    chk("R7 second index", int'(position), 0);
    chk("R8 sticky", int'(indexSeen), 1);

    done = 1;
    finishRun();
  end
endmodule